// File: doc/BRIEF.md
# Monochrome Bitmap Raster Controller

This block scans a one-bit-per-pixel bitmap out of a shared 32 KB RAM onto a VGA-compatible monitor. It runs from a 12 MHz system clock and has 576 visible pixels on each of 455 visible lines. Across the whole frame that is 16380 words of 16 bits, so the picture covers almost every bit of the RAM. Because a line lasts only 384 clocks, the block delivers two pixels per clock. The port `video[1]` carries the left pixel of each pair and `video[0]` the right one. The board logic serialises the pair at twice the clock rate.

Frame-buffer words are read through a request/acknowledge port that a memory arbiter serves. A request is raised ahead of the clock on which the word is needed, and the returned word is parked in a one-word holding register. On each word boundary in the visible area, the holding word moves into a shift register that emits its bits most significant first. The word address starts at zero at the start of every vertical blanking interval and then steps by one per fetch. Memory is therefore shown linearly, starting at address 0 in the top-left corner.

The scan geometry is parameterised: visible width in clocks, front porch, sync width and back porch, for both the horizontal and the vertical direction. The defaults give 384 clocks per line (about 31.25 kHz) and 525 lines per frame (about 59.5 Hz). Both sync pulses are active low.

Top module: `mono_bitmap_vga`

## Requirements
- R1: While `rst_n` is low, `hsync_n` and `vsync_n` are 1, `video` is 0, `mem_req` is 0 and `mem_addr` is 0. After release, the scan starts at column 0 of line 455, which is the first line after the visible lines.
- R2: A line is 384 clocks long, numbered as columns 0 to 383. `hsync_n` is 0 for columns 298 to 343 (46 clocks) and 1 for all other columns. Every output is registered, so each output shows the column and line that the scan held one clock earlier.
- R3: A frame is 525 lines long, numbered 0 to 524. `vsync_n` is 0 throughout lines 479 and 480, and 1 on all other lines. Its edges line up with column 0.
- R4: On lines 0 to 454, columns 0 to 287 are visible. Visible column c of line v shows word v*36 + c/8. The output `video[1]` takes bit 15-2*(c mod 8) of that word, and `video[0]` takes the bit just below it.
- R5: `video` is 00 on every column and line outside the visible area.
- R6: Once `mem_req` rises, it stays high until a clock edge samples `mem_ack` high. `mem_rdata` is captured at that same edge. `mem_addr` holds its value while a request waits and increments by one after each acknowledged request.
- R7: `mem_addr` returns to 0 on the first clock of line 455. After that it never goes above 16380, so every visible frame starts at word 0.
- R8: The picture is the same for any acknowledge that arrives 1 to 7 clocks after `mem_req` rises.
- R9: `mem_req` rises only after scan positions of two kinds:
  - column 376 of line 524 or of lines 0 to 453, which prefetches the first word of the next visible line;
  - columns 0, 8, ..., 272 of a visible line.

  It rises after each of these positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (12 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| video | output | PIX_PER_CLK (2) | Pixel pair, bit 1 is the left pixel |
| mem_req | output | 1 | Frame-buffer read request, held until acknowledged |
| mem_addr | output | ADDR_W (14) | Word address of the requested frame-buffer word |
| mem_ack | input | 1 | Read acknowledge, one clock, with data valid |
| mem_rdata | input | WORD_W (16) | Returned frame-buffer word |

## Verification
A wrong counter or sync decode shows up at once as a sync edge in the wrong column or line, or of the wrong width. The check is made against a scan position that is derived from the number of clocks since reset.

A slip in the address counter or the fetch timing corrupts the pixel pairs from the first word that is wrong. The words returned from memory are a known function of the address, so a single word that is wrong, late or misplaced is caught within eight clocks.

Request timing is checked at every rising edge of `mem_req`. Running at both the shortest and the longest acknowledge latency exposes a prefetch that is too late.

// File: rtl/mvga_pkg.sv
package mvga_pkg;

    // Per-clock decode of the scan position, shared by fetch and shift logic.
    typedef struct packed {
        logic active;     // position lies in the visible area
        logic load;       // first clock of a word in the visible area
        logic fetch;      // raise a frame-buffer request after this clock
        logic frame_rst;  // first clock of vertical blanking
        logic hsync_n;
        logic vsync_n;
    } scan_t;

endpackage

// File: rtl/mvga_scan.sv
module mvga_scan
    import mvga_pkg::*;
#(
    parameter int H_ACTIVE = 288,
    parameter int H_FRONT  = 10,
    parameter int H_SYNC   = 46,
    parameter int H_BACK   = 40,
    parameter int V_ACTIVE = 455,
    parameter int V_FRONT  = 24,
    parameter int V_SYNC   = 2,
    parameter int V_BACK   = 44,
    parameter int CPW      = 8     // clocks per word, power of two
) (
    input  logic  clk,
    input  logic  rst_n,
    output scan_t scan
);
    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
    localparam int HW = $clog2(H_TOTAL);
    localparam int VW = $clog2(V_TOTAL);
    localparam int CW = $clog2(CPW);

    localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] H_VIS   = HW'(H_ACTIVE);
    localparam logic [HW-1:0] H_SS    = HW'(H_ACTIVE + H_FRONT);
    localparam logic [HW-1:0] H_SE    = HW'(H_ACTIVE + H_FRONT + H_SYNC);
    localparam logic [HW-1:0] H_PRE   = HW'(H_TOTAL - CPW);
    localparam logic [HW-1:0] H_LASTW = HW'(H_ACTIVE - CPW);
    localparam logic [VW-1:0] V_LAST  = VW'(V_TOTAL - 1);
    localparam logic [VW-1:0] V_VIS   = VW'(V_ACTIVE);
    localparam logic [VW-1:0] V_PRE   = VW'(V_ACTIVE - 1);
    localparam logic [VW-1:0] V_SS    = VW'(V_ACTIVE + V_FRONT);
    localparam logic [VW-1:0] V_SE    = VW'(V_ACTIVE + V_FRONT + V_SYNC);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (pos_q.h == H_LAST) begin
            pos_d.h = '0;
            pos_d.v = (pos_q.v == V_LAST) ? '0 : pos_q.v + 1'b1;
        end else begin
            pos_d.h = pos_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q.h <= '0;
            pos_q.v <= V_VIS;
        end else begin
            pos_q <= pos_d;
        end
    end

    logic vis_line, next_vis, word_edge;

    always_comb begin
        vis_line       = pos_q.v < V_VIS;
        next_vis       = (pos_q.v == V_LAST) || (pos_q.v < V_PRE);
        word_edge      = pos_q.h[CW-1:0] == '0;
        scan.active    = vis_line && (pos_q.h < H_VIS);
        scan.load      = scan.active && word_edge;
        scan.fetch     = (scan.load && (pos_q.h < H_LASTW))
                       || ((pos_q.h == H_PRE) && next_vis);
        scan.frame_rst = (pos_q.v == V_VIS) && (pos_q.h == '0);
        scan.hsync_n   = !((pos_q.h >= H_SS) && (pos_q.h < H_SE));
        scan.vsync_n   = !((pos_q.v >= V_SS) && (pos_q.v < V_SE));
    end

endmodule

// File: rtl/mvga_fetch.sv
module mvga_fetch
    import mvga_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  scan_t             scan,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] held_word
);
    typedef struct packed {
        logic              req;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] word;
    } fetch_t;

    fetch_t f_d, f_q;

    always_comb begin
        f_d     = f_q;
        f_d.req = scan.fetch || (f_q.req && !mem_ack);
        if (f_q.req && mem_ack) begin
            f_d.addr = f_q.addr + 1'b1;
            f_d.word = mem_rdata;
        end
        if (scan.frame_rst) begin
            f_d.addr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign mem_req   = f_q.req;
    assign mem_addr  = f_q.addr;
    assign held_word = f_q.word;

endmodule

// File: rtl/mvga_shift.sv
module mvga_shift
    import mvga_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int PIX_PER_CLK = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  scan_t                  scan,
    input  logic [WORD_W-1:0]      held_word,
    output logic [PIX_PER_CLK-1:0] video,
    output logic                   hsync_n,
    output logic                   vsync_n
);
    typedef struct packed {
        logic [WORD_W-1:0]      shreg;
        logic [PIX_PER_CLK-1:0] pix;
        logic                   hs_n;
        logic                   vs_n;
    } shift_t;

    shift_t s_d, s_q;
    logic [WORD_W-1:0] src;

    always_comb begin
        s_d      = s_q;
        src      = scan.load ? held_word : s_q.shreg;
        s_d.hs_n = scan.hsync_n;
        s_d.vs_n = scan.vsync_n;
        if (scan.active) begin
            s_d.pix   = src[WORD_W-1 -: PIX_PER_CLK];
            s_d.shreg = src << PIX_PER_CLK;
        end else begin
            s_d.pix   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.shreg <= '0;
            s_q.pix   <= '0;
            s_q.hs_n  <= 1'b1;
            s_q.vs_n  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign video   = s_q.pix;
    assign hsync_n = s_q.hs_n;
    assign vsync_n = s_q.vs_n;

endmodule

// File: rtl/mono_bitmap_vga.sv
module mono_bitmap_vga
    import mvga_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int PIX_PER_CLK = 2,
    parameter int ADDR_W      = 14,
    parameter int H_ACTIVE    = 288,
    parameter int H_FRONT     = 10,
    parameter int H_SYNC      = 46,
    parameter int H_BACK      = 40,
    parameter int V_ACTIVE    = 455,
    parameter int V_FRONT     = 24,
    parameter int V_SYNC      = 2,
    parameter int V_BACK      = 44
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic                   hsync_n,
    output logic                   vsync_n,
    output logic [PIX_PER_CLK-1:0] video,
    output logic                   mem_req,
    output logic [ADDR_W-1:0]      mem_addr,
    input  logic                   mem_ack,
    input  logic [WORD_W-1:0]      mem_rdata
);
    localparam int CPW = WORD_W / PIX_PER_CLK;

    scan_t             scan;
    logic [WORD_W-1:0] held_word;

    mvga_scan #(
        .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
        .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
        .CPW(CPW)
    ) u_scan (
        .clk  (clk),
        .rst_n(rst_n),
        .scan (scan)
    );

    mvga_fetch #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan     (scan),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .held_word(held_word)
    );

    mvga_shift #(.WORD_W(WORD_W), .PIX_PER_CLK(PIX_PER_CLK)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan     (scan),
        .held_word(held_word),
        .video    (video),
        .hsync_n  (hsync_n),
        .vsync_n  (vsync_n)
    );

endmodule

// File: rtl/mono_bitmap_vga_chk.sv
module mono_bitmap_vga_chk #(
    parameter int WORD_W      = 16,
    parameter int PIX_PER_CLK = 2,
    parameter int ADDR_W      = 14,
    parameter int H_ACTIVE    = 288,
    parameter int H_SYNC      = 46,
    parameter int V_ACTIVE    = 455
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   hsync_n,
    input logic                   vsync_n,
    input logic [PIX_PER_CLK-1:0] video,
    input logic                   mem_req,
    input logic [ADDR_W-1:0]      mem_addr,
    input logic                   mem_ack,
    input logic [WORD_W-1:0]      mem_rdata
);
    localparam int WPL = H_ACTIVE * PIX_PER_CLK / WORD_W;
    localparam logic [ADDR_W-1:0] ADDR_MAX = ADDR_W'(WPL * V_ACTIVE);

    logic [15:0] hlow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hlow_q <= '0;
        end else if (!hsync_n) begin
            hlow_q <= hlow_q + 1'b1;
        end else begin
            hlow_q <= '0;
        end
    end

    AST_HSYNC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_n) |-> (hlow_q == 16'(H_SYNC)));                        // R2

    AST_VIDEO_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (!hsync_n || !vsync_n) |-> (video == '0));                          // R5

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req);                                 // R6

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (mem_addr == $past(mem_addr) + 1'b1));     // R6

    AST_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && mem_ack) |=> ((mem_addr == $past(mem_addr)) || (mem_addr == '0))); // R7

    AST_ADDR_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr <= ADDR_MAX);                                              // R7

endmodule

bind mono_bitmap_vga mono_bitmap_vga_chk #(
    .WORD_W(WORD_W), .PIX_PER_CLK(PIX_PER_CLK), .ADDR_W(ADDR_W),
    .H_ACTIVE(H_ACTIVE), .H_SYNC(H_SYNC), .V_ACTIVE(V_ACTIVE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .video(video), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
);

// File: tb/mono_bitmap_vga_tb.sv
module mono_bitmap_vga_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W = 16;
    localparam int PIX    = 2;
    localparam int ADDR_W = 14;
    localparam int HA = 24, HFP = 4, HS = 8, HBP = 12;
    localparam int VA = 4,  VFP = 1, VS = 2, VBP = 3;
    localparam int HT = HA + HFP + HS + HBP;
    localparam int VT = VA + VFP + VS + VBP;
    localparam int CPW = WORD_W / PIX;
    localparam int WPL = HA / CPW;
    localparam int FRAME = HT * VT;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hsync_n, vsync_n;
    logic [PIX-1:0]    video;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_ack = 1'b0;
    logic [WORD_W-1:0] mem_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int latency  = 1;
    bit finished = 1'b0;

    mono_bitmap_vga #(
        .WORD_W(WORD_W), .PIX_PER_CLK(PIX), .ADDR_W(ADDR_W),
        .H_ACTIVE(HA), .H_FRONT(HFP), .H_SYNC(HS), .H_BACK(HBP),
        .V_ACTIVE(VA), .V_FRONT(VFP), .V_SYNC(VS), .V_BACK(VBP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .video(video), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [WORD_W-1:0] pattern(input int a);
        return WORD_W'((a * 40503 + 12345) ^ (a << 7));
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Memory model: acknowledge after `latency` clocks, data is a function of the address.
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rst_n && mem_req) begin
                cnt++;
                if (cnt >= latency) begin
                    mem_ack   = 1'b1;
                    mem_rdata = pattern(int'(mem_addr));
                    cnt       = 0;
                end
            end else begin
                cnt = 0;
            end
        end
    end

    // R1: reset values, then release on a falling edge.
    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(hsync_n == 1'b1, "R1 hsync_n in reset", int'(hsync_n), 1);
        check(vsync_n == 1'b1, "R1 vsync_n in reset", int'(vsync_n), 1);
        check(video == '0,     "R1 video in reset",   int'(video), 0);
        check(mem_req == 1'b0, "R1 mem_req in reset", int'(mem_req), 0);
        check(mem_addr == '0,  "R1 mem_addr in reset", int'(mem_addr), 0);
        rst_n = 1'b1;
    endtask

    // Compare all outputs every clock against a scan position derived from clocks since reset.
    task automatic run_scan(input int lat, input int nclk);
        bit prev_req;
        latency  = lat;
        apply_reset();
        prev_req = 1'b0;
        for (int k = 1; k <= nclk; k++) begin
            int p, h, v, exp_v, exp_hs, exp_vs, bitpos;
            bit vis, fetch_pt, rose;
            @(negedge clk);
            p = k - 1;
            h = p % HT;
            v = (VA + p / HT) % VT;
            vis = (v < VA) && (h < HA);
            if (vis) begin
                bitpos = WORD_W - 1 - PIX * (h % CPW);
                exp_v  = int'((pattern(v * WPL + h / CPW) >> (bitpos - 1)) & 3);
                check(int'(video) == exp_v, "R4 R8 visible pixel pair", int'(video), exp_v);
            end else begin
                check(video == '0, "R5 blank video", int'(video), 0);
            end
            exp_hs = ((h >= HA + HFP) && (h < HA + HFP + HS)) ? 0 : 1;
            exp_vs = ((v >= VA + VFP) && (v < VA + VFP + VS)) ? 0 : 1;
            check(int'(hsync_n) == exp_hs, "R2 hsync_n", int'(hsync_n), exp_hs);
            check(int'(vsync_n) == exp_vs, "R3 vsync_n", int'(vsync_n), exp_vs);
            fetch_pt = (vis && (h % CPW == 0) && (h < HA - CPW))
                     || ((h == HT - CPW) && ((v == VT - 1) || (v < VA - 1)));
            rose = mem_req && !prev_req;
            check(rose == fetch_pt, "R6/R9 request rise", int'(rose), int'(fetch_pt));
            prev_req = mem_req;
            if ((v == VA) && (h == 0)) begin
                check(mem_addr == '0, "R7 address restart", int'(mem_addr), 0);
            end
            check(int'(mem_addr) <= WPL * VA, "R7 address bound", int'(mem_addr), WPL * VA);
        end
    endtask

    task automatic t_reset_state();
        apply_reset();
    endtask

    task automatic t_fast_memory();
        run_scan(1, 2 * FRAME);
    endtask

    task automatic t_slow_memory();  // R8: longest tolerated acknowledge latency
        run_scan(7, 2 * FRAME);
    endtask

    task automatic t_mid_frame_reset();  // R1: reset from the middle of a frame
        run_scan(3, FRAME + HT * 3 + 17);
        run_scan(4, 2 * FRAME);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_fast_memory();
        t_slow_memory();
        t_mid_frame_reset();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule